// File: doc/BRIEF.md
# Replicated Snoop-Request Arbiter

This block orders coherence snoop requests on a shared broadcast bus whose nodes each own a private transmit slot. No central grant is exchanged. Every node first picks one request from its attached caches and places it in its own slot. It then runs a copy of one global arbitration over all occupied slots. Because every copy starts from the same reset state and sees the same slot contents and completion events, all copies reach the same outcome independently.

Each request ends in exactly one of three answers: granted, told to retry, or deferred. A request is deferred when its cache line already has a transaction outstanding. Each node keeps its own table of outstanding lines. An entry is released when the final snoop result of its transaction has been delivered, which the completion input reports. Granted requests are also presented, in priority order, on a per-node delivery stream toward the caches.

Top module: `snoop_bus_arb`

## Requirements
- R1: Each node forwards at most one request per cycle. It picks it round-robin among its caches, starting at the cache after the previous local winner, with cache 0 first after reset. Every other requesting cache of that node is answered with retry.
- R2: A request presented on `req_vld_i` in one cycle is answered with exactly one of grant, retry or defer two clock edges later. No answer appears for a cache that made no request.
- R3: All node copies produce the same delivery stream (valid lanes, addresses and sources) in every cycle.
- R4: Occupied slots are examined in node order, starting at a rotating pointer and wrapping around. The pointer is 0 after reset and advances by one in every cycle in which at least one slot is occupied.
- R5: The line of an address is bits [ADDR_W-1:LINE_OFS]. A slot whose line is in the outstanding table is deferred. This includes a line whose completion arrives at the same edge.
- R6: A slot whose line equals that of a slot granted earlier in the same examination is answered with retry.
- R7: At most SEL_MAX slots are granted per cycle, and no more than the number of table entries that are free before that edge's completion is applied. Any further slots are answered with retry.
- R8: A granted line enters the outstanding table at the edge that issues the grant. `done_vld_i` with `done_line_i` removes a matching entry, after which a new request to that line can be granted. A completion for a line that is not outstanding changes nothing.
- R9: Delivery lanes are filled from lane 0 upward in examination order. Each lane carries the full address and a source index of node*CACHES+cache (node in the upper bits). It appears at the same edge as the grants, and unused lanes read zero.
- R10: During reset all grant, retry, defer and delivery outputs are zero and the outstanding tables are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_vld_i | input | NODES*CACHES | Per-cache request strobe |
| req_addr_i | input | NODES*CACHES*ADDR_W | Per-cache address-and-command word |
| done_vld_i | input | 1 | Final snoop result delivered for a transaction |
| done_line_i | input | ADDR_W-LINE_OFS | Line of the completed transaction |
| grant_o | output | NODES*CACHES | Per-cache grant answer |
| retry_o | output | NODES*CACHES | Per-cache retry answer |
| defer_o | output | NODES*CACHES | Per-cache defer answer |
| dlv_vld_o | output | NODES*SEL_MAX | Per-node delivery lane valid |
| dlv_addr_o | output | NODES*SEL_MAX*ADDR_W | Per-node delivery lane address |
| dlv_src_o | output | NODES*SEL_MAX*(clog2(NODES)+clog2(CACHES)) | Per-node delivery lane source index |

## Verification
The hardest case to reach is a full outstanding table. In that state, capacity retries mix with defers, and a completion and a request to the same line land on the same edge. Random traffic rarely gets there. The stimulus therefore draws addresses from a pool of only ten lines against an eight-entry table. It then moves through phases of heavy requests with few completions, sparse requests with many completions, and a final flood. This keeps the table swinging between empty and full, and it exercises the rotating pointer under every mix of defers, duplicates and capacity limits.

// File: rtl/snarb_pkg.sv
package snarb_pkg;
  typedef enum logic [1:0] {
    RES_NONE  = 2'd0,
    RES_GRANT = 2'd1,
    RES_RETRY = 2'd2,
    RES_DEFER = 2'd3
  } res_e;
endpackage

// File: rtl/snarb_local.sv
module snarb_local #(
  parameter int CACHES = 4,
  parameter int ADDR_W = 64,
  parameter int SRC_W  = $clog2(CACHES)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [CACHES-1:0]        req_vld_i,
  input  logic [CACHES*ADDR_W-1:0] req_addr_i,
  output logic                     slot_vld_o,
  output logic [ADDR_W-1:0]        slot_addr_o,
  output logic [SRC_W-1:0]         slot_src_o,
  output logic [CACHES-1:0]        lose_o
);
  logic [SRC_W-1:0]  ptr_q, win;
  logic [CACHES-1:0] win_oh;
  logic              found;

  always_comb begin
    found  = 1'b0;
    win    = '0;
    for (int i = 0; i < CACHES; i++) begin
      if (!found && req_vld_i[(int'(ptr_q) + i) % CACHES]) begin
        found = 1'b1;
        win   = SRC_W'((int'(ptr_q) + i) % CACHES);
      end
    end
    win_oh = found ? (CACHES'(1) << win) : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q       <= '0;
      slot_vld_o  <= 1'b0;
      slot_addr_o <= '0;
      slot_src_o  <= '0;
      lose_o      <= '0;
    end else begin
      slot_vld_o  <= found;
      slot_addr_o <= req_addr_i[int'(win)*ADDR_W +: ADDR_W];
      slot_src_o  <= win;
      lose_o      <= req_vld_i & ~win_oh;
      if (found) ptr_q <= SRC_W'((int'(win) + 1) % CACHES);
    end
  end
endmodule

// File: rtl/snarb_global.sv
module snarb_global
  import snarb_pkg::*;
#(
  parameter int NODES   = 4,
  parameter int LINE_W  = 58,
  parameter int SEL_MAX = 4,
  parameter int DEPTH   = 8,
  parameter int OWN     = 0,
  parameter int NW      = $clog2(NODES)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NODES-1:0]        slot_vld_i,
  input  logic [NODES*LINE_W-1:0] slot_line_i,
  input  logic                    done_vld_i,
  input  logic [LINE_W-1:0]       done_line_i,
  output res_e                    own_res_o,
  output logic [SEL_MAX-1:0]      sel_vld_o,
  output logic [SEL_MAX*NW-1:0]   sel_slot_o
);
  logic [NW-1:0]     ptr_q, ptr_n;
  logic [DEPTH-1:0]  ent_vld_q, ent_vld_n;
  logic [LINE_W-1:0] ent_line_q [DEPTH];
  logic [LINE_W-1:0] ent_line_n [DEPTH];
  logic [NODES-1:0]  gmask;
  res_e              res [NODES];

  always_comb begin
    int free, cnt, s;
    logic hit, dup;
    logic [LINE_W-1:0] ln;
    free = 0;
    for (int e = 0; e < DEPTH; e++) free += ent_vld_q[e] ? 0 : 1;
    cnt        = 0;
    gmask      = '0;
    sel_vld_o  = '0;
    sel_slot_o = '0;
    for (int i = 0; i < NODES; i++) res[i] = RES_NONE;
    for (int i = 0; i < NODES; i++) begin
      s   = (int'(ptr_q) + i) % NODES;
      ln  = slot_line_i[s*LINE_W +: LINE_W];
      hit = 1'b0;
      for (int e = 0; e < DEPTH; e++)
        if (ent_vld_q[e] && ent_line_q[e] == ln) hit = 1'b1;
      dup = 1'b0;
      for (int j = 0; j < NODES; j++)
        if (gmask[j] && slot_line_i[j*LINE_W +: LINE_W] == ln) dup = 1'b1;
      if (slot_vld_i[s]) begin
        if (hit) res[s] = RES_DEFER;
        else if (dup) res[s] = RES_RETRY;
        else if (cnt >= SEL_MAX || cnt >= free) res[s] = RES_RETRY;
        else begin
          res[s]                     = RES_GRANT;
          gmask[s]                   = 1'b1;
          sel_vld_o[cnt]             = 1'b1;
          sel_slot_o[cnt*NW +: NW]   = NW'(s);
          cnt++;
        end
      end
    end
    own_res_o = res[OWN];
  end

  // table next state: release on completion, fill pre-edge free entries
  always_comb begin
    logic [DEPTH-1:0] taken;
    logic placed;
    ent_vld_n = ent_vld_q;
    taken     = '0;
    for (int e = 0; e < DEPTH; e++) begin
      ent_line_n[e] = ent_line_q[e];
      if (done_vld_i && ent_vld_q[e] && ent_line_q[e] == done_line_i) ent_vld_n[e] = 1'b0;
    end
    for (int k = 0; k < SEL_MAX; k++) begin
      placed = 1'b0;
      for (int e = 0; e < DEPTH; e++) begin
        if (sel_vld_o[k] && !placed && !ent_vld_q[e] && !taken[e]) begin
          placed        = 1'b1;
          taken[e]      = 1'b1;
          ent_vld_n[e]  = 1'b1;
          ent_line_n[e] = slot_line_i[int'(sel_slot_o[k*NW +: NW])*LINE_W +: LINE_W];
        end
      end
    end
    ptr_n = (|slot_vld_i) ? NW'((int'(ptr_q) + 1) % NODES) : ptr_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q     <= '0;
      ent_vld_q <= '0;
      for (int e = 0; e < DEPTH; e++) ent_line_q[e] <= '0;
    end else begin
      ptr_q     <= ptr_n;
      ent_vld_q <= ent_vld_n;
      for (int e = 0; e < DEPTH; e++) ent_line_q[e] <= ent_line_n[e];
    end
  end
endmodule

// File: rtl/snoop_bus_arb.sv
module snoop_bus_arb
  import snarb_pkg::*;
#(
  parameter int NODES    = 4,
  parameter int CACHES   = 4,
  parameter int ADDR_W   = 64,
  parameter int LINE_OFS = 6,
  parameter int SEL_MAX  = 4,
  parameter int DEPTH    = 8
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic [NODES*CACHES-1:0]             req_vld_i,
  input  logic [NODES*CACHES*ADDR_W-1:0]      req_addr_i,
  input  logic                                done_vld_i,
  input  logic [ADDR_W-LINE_OFS-1:0]          done_line_i,
  output logic [NODES*CACHES-1:0]             grant_o,
  output logic [NODES*CACHES-1:0]             retry_o,
  output logic [NODES*CACHES-1:0]             defer_o,
  output logic [NODES*SEL_MAX-1:0]            dlv_vld_o,
  output logic [NODES*SEL_MAX*ADDR_W-1:0]     dlv_addr_o,
  output logic [NODES*SEL_MAX*($clog2(NODES)+$clog2(CACHES))-1:0] dlv_src_o
);
  localparam int NW     = $clog2(NODES);
  localparam int CW     = $clog2(CACHES);
  localparam int SRC_W  = NW + CW;
  localparam int LINE_W = ADDR_W - LINE_OFS;
  localparam int NC     = NODES * CACHES;
  localparam int LANES  = NODES * SEL_MAX;

  logic [NODES-1:0]        slot_vld;
  logic [NODES*ADDR_W-1:0] slot_addr;
  logic [NODES*LINE_W-1:0] slot_line;
  logic [NODES*CW-1:0]     slot_src;
  logic [NC-1:0]           lose;
  res_e                    own_res [NODES];
  logic [LANES-1:0]        gsel_vld;
  logic [LANES*NW-1:0]     gsel_slot;

  for (genvar n = 0; n < NODES; n++) begin : g_node
    snarb_local #(.CACHES(CACHES), .ADDR_W(ADDR_W), .SRC_W(CW)) u_loc (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .req_vld_i  (req_vld_i[n*CACHES +: CACHES]),
      .req_addr_i (req_addr_i[n*CACHES*ADDR_W +: CACHES*ADDR_W]),
      .slot_vld_o (slot_vld[n]),
      .slot_addr_o(slot_addr[n*ADDR_W +: ADDR_W]),
      .slot_src_o (slot_src[n*CW +: CW]),
      .lose_o     (lose[n*CACHES +: CACHES])
    );
    assign slot_line[n*LINE_W +: LINE_W] = slot_addr[n*ADDR_W+LINE_OFS +: LINE_W];
  end

  // one identical arbitration copy per node, fed by the shared slots
  for (genvar n = 0; n < NODES; n++) begin : g_copy
    snarb_global #(.NODES(NODES), .LINE_W(LINE_W), .SEL_MAX(SEL_MAX),
                   .DEPTH(DEPTH), .OWN(n), .NW(NW)) u_glb (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .slot_vld_i (slot_vld),
      .slot_line_i(slot_line),
      .done_vld_i (done_vld_i),
      .done_line_i(done_line_i),
      .own_res_o  (own_res[n]),
      .sel_vld_o  (gsel_vld[n*SEL_MAX +: SEL_MAX]),
      .sel_slot_o (gsel_slot[n*SEL_MAX*NW +: SEL_MAX*NW])
    );
  end

  logic [NC-1:0]            grant_d, retry_d, defer_d;
  logic [LANES*ADDR_W-1:0]  addr_d;
  logic [LANES*SRC_W-1:0]   src_d;

  always_comb begin
    logic here;
    int lane, s;
    for (int n = 0; n < NODES; n++) begin
      for (int c = 0; c < CACHES; c++) begin
        here = slot_vld[n] && slot_src[n*CW +: CW] == CW'(c);
        grant_d[n*CACHES+c] = here && own_res[n] == RES_GRANT;
        defer_d[n*CACHES+c] = here && own_res[n] == RES_DEFER;
        retry_d[n*CACHES+c] = lose[n*CACHES+c] || (here && own_res[n] == RES_RETRY);
      end
    end
    for (int n = 0; n < NODES; n++) begin
      for (int k = 0; k < SEL_MAX; k++) begin
        lane = n*SEL_MAX + k;
        s    = int'(gsel_slot[lane*NW +: NW]);
        addr_d[lane*ADDR_W +: ADDR_W] = '0;
        src_d[lane*SRC_W +: SRC_W]    = '0;
        if (gsel_vld[lane]) begin
          addr_d[lane*ADDR_W +: ADDR_W] = slot_addr[s*ADDR_W +: ADDR_W];
          src_d[lane*SRC_W +: SRC_W]    = {NW'(s), slot_src[s*CW +: CW]};
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_o    <= '0;
      retry_o    <= '0;
      defer_o    <= '0;
      dlv_vld_o  <= '0;
      dlv_addr_o <= '0;
      dlv_src_o  <= '0;
    end else begin
      grant_o    <= grant_d;
      retry_o    <= retry_d;
      defer_o    <= defer_d;
      dlv_vld_o  <= gsel_vld;
      dlv_addr_o <= addr_d;
      dlv_src_o  <= src_d;
    end
  end
endmodule

// File: rtl/snarb_chk.sv
module snarb_chk #(
  parameter int NODES    = 4,
  parameter int CACHES   = 4,
  parameter int ADDR_W   = 64,
  parameter int LINE_OFS = 6,
  parameter int SEL_MAX  = 4
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic [NODES*CACHES-1:0]         req_vld_i,
  input logic [NODES*CACHES-1:0]         grant_o,
  input logic [NODES*CACHES-1:0]         retry_o,
  input logic [NODES*CACHES-1:0]         defer_o,
  input logic [NODES*SEL_MAX-1:0]        dlv_vld_o,
  input logic [NODES*SEL_MAX*ADDR_W-1:0] dlv_addr_o
);
  localparam int NC     = NODES * CACHES;
  localparam int LINE_W = ADDR_W - LINE_OFS;

  for (genvar c = 0; c < NC; c++) begin : g_cache
    p_one_resp_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({grant_o[c], retry_o[c], defer_o[c]}));
    p_resp_after_req_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (grant_o[c] || retry_o[c] || defer_o[c]) |-> $past(req_vld_i[c], 2));
  end

  for (genvar n = 1; n < NODES; n++) begin : g_agree
    p_agree_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dlv_vld_o[n*SEL_MAX +: SEL_MAX] == dlv_vld_o[SEL_MAX-1:0] &&
      dlv_addr_o[n*SEL_MAX*ADDR_W +: SEL_MAX*ADDR_W] == dlv_addr_o[SEL_MAX*ADDR_W-1:0]);
  end

  p_grant_match_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(dlv_vld_o[SEL_MAX-1:0]) == $countones(grant_o));

  p_cap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(grant_o) <= SEL_MAX);

  for (genvar k = 1; k < SEL_MAX; k++) begin : g_pack
    p_pack_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dlv_vld_o[k] |-> dlv_vld_o[k-1]);
  end

  for (genvar j = 0; j < SEL_MAX; j++) begin : g_dj
    for (genvar k = j + 1; k < SEL_MAX; k++) begin : g_dk
      p_line_distinct_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dlv_vld_o[j] && dlv_vld_o[k]) |->
        dlv_addr_o[j*ADDR_W+LINE_OFS +: LINE_W] != dlv_addr_o[k*ADDR_W+LINE_OFS +: LINE_W]);
    end
  end
endmodule

bind snoop_bus_arb snarb_chk #(
  .NODES(NODES), .CACHES(CACHES), .ADDR_W(ADDR_W),
  .LINE_OFS(LINE_OFS), .SEL_MAX(SEL_MAX)
) u_chk (.*);

// File: tb/sim_snoop_bus_arb.sv
module sim_snoop_bus_arb;
  localparam int CLK_PERIOD = 10;
  localparam int NODES = 4, CACHES = 4, ADDR_W = 64, LINE_OFS = 6, SEL_MAX = 4, DEPTH = 8;
  localparam int NC = NODES * CACHES;
  localparam int SRC_W = 4;
  localparam int LINE_W = ADDR_W - LINE_OFS;
  localparam int POOL = 10;
  localparam logic [LINE_W-1:0] LBASE = LINE_W'(58'h12_3450);

  typedef struct packed {
    logic [NC-1:0] g, r, d;
    logic [SEL_MAX-1:0] sv;
    logic [SEL_MAX*ADDR_W-1:0] sa;
    logic [SEL_MAX*SRC_W-1:0] ss;
  } exp_t;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [NC-1:0] req_vld = '0;
  logic [NC*ADDR_W-1:0] req_addr = '0;
  logic done_vld = 1'b0;
  logic [LINE_W-1:0] done_line = '0;
  logic [NC-1:0] grant, retry, defer;
  logic [NODES*SEL_MAX-1:0] dlv_vld;
  logic [NODES*SEL_MAX*ADDR_W-1:0] dlv_addr;
  logic [NODES*SEL_MAX*SRC_W-1:0] dlv_src;

  int total = 0, bad = 0;
  bit finished = 0;
  exp_t q[$];

  int lptr[NODES];
  int gptr = 0;
  bit tv[DEPTH];
  logic [LINE_W-1:0] tl[DEPTH];
  bit pv[NODES];
  logic [ADDR_W-1:0] pa[NODES];
  int psrc[NODES];
  logic [NC-1:0] plose = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  snoop_bus_arb u0 (
    .clk_i(clk), .rst_ni(rst_ni), .req_vld_i(req_vld), .req_addr_i(req_addr),
    .done_vld_i(done_vld), .done_line_i(done_line),
    .grant_o(grant), .retry_o(retry), .defer_o(defer),
    .dlv_vld_o(dlv_vld), .dlv_addr_o(dlv_addr), .dlv_src_o(dlv_src)
  );

  task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // monitor: compare design outputs with the oldest expected item
  task automatic mon_step();
    exp_t e;
    if (q.size() == 0) return;
    e = q.pop_front();
    chk("R2 R4 R8 grant", 256'(grant), 256'(e.g));
    chk("R1 R6 R7 retry", 256'(retry), 256'(e.r));
    chk("R5 defer", 256'(defer), 256'(e.d));
    for (int n = 0; n < NODES; n++) begin
      chk("R3 R9 lane valid", 256'(dlv_vld[n*SEL_MAX +: SEL_MAX]), 256'(e.sv));
      chk("R3 R9 lane addr", 256'(dlv_addr[n*SEL_MAX*ADDR_W +: SEL_MAX*ADDR_W]), 256'(e.sa));
      chk("R3 R9 lane src", 256'(dlv_src[n*SEL_MAX*SRC_W +: SEL_MAX*SRC_W]), 256'(e.ss));
    end
  endtask

  // driver, global part: model R4-R9 on the pending slots, drive completion
  task automatic global_step(input int done_pct);
    exp_t e;
    int free, cnt, s, cidx, pick;
    bit hit, dup, any;
    logic [LINE_W-1:0] ln;
    logic [LINE_W-1:0] gl[SEL_MAX];
    e = '0;
    e.r = plose;
    free = 0;
    for (int k = 0; k < DEPTH; k++) if (!tv[k]) free++;
    cnt = 0;
    any = 0;
    for (int i = 0; i < NODES; i++) begin
      s = (gptr + i) % NODES;
      if (!pv[s]) continue;
      any = 1;
      ln = pa[s][ADDR_W-1:LINE_OFS];
      cidx = s * CACHES + psrc[s];
      hit = 0;
      for (int k = 0; k < DEPTH; k++) if (tv[k] && tl[k] == ln) hit = 1;
      dup = 0;
      for (int k = 0; k < cnt; k++) if (gl[k] == ln) dup = 1;
      if (hit) e.d[cidx] = 1'b1;
      else if (dup || cnt >= SEL_MAX || cnt >= free) e.r[cidx] = 1'b1;
      else begin
        e.g[cidx] = 1'b1;
        e.sv[cnt] = 1'b1;
        e.sa[cnt*ADDR_W +: ADDR_W] = pa[s];
        e.ss[cnt*SRC_W +: SRC_W] = SRC_W'(cidx);
        gl[cnt] = ln;
        cnt++;
      end
    end
    if (any) gptr = (gptr + 1) % NODES;
    done_vld = 1'b0;
    if (int'($urandom % 100) < done_pct) begin
      done_vld = 1'b1;
      pick = int'($urandom % DEPTH);
      if (tv[pick] && ($urandom % 4) != 0) done_line = tl[pick];
      else done_line = LBASE + LINE_W'($urandom % POOL);
      for (int k = 0; k < DEPTH; k++) if (tv[k] && tl[k] == done_line) tv[k] = 0;
    end
    for (int j = 0; j < cnt; j++) begin
      for (int k = 0; k < DEPTH; k++) begin
        if (!tv[k]) begin
          tv[k] = 1;
          tl[k] = gl[j];
          break;
        end
      end
    end
    q.push_back(e);
  endtask

  // driver, local part: random requests and the R1 round-robin model
  task automatic local_step(input int req_pct);
    bit found;
    int c;
    plose = '0;
    for (int i = 0; i < NC; i++) begin
      req_vld[i] = (int'($urandom % 100) < req_pct);
      req_addr[i*ADDR_W +: ADDR_W] = {LBASE + LINE_W'($urandom % POOL), LINE_OFS'($urandom)};
    end
    for (int n = 0; n < NODES; n++) begin
      found = 0;
      for (int i = 0; i < CACHES; i++) begin
        c = (lptr[n] + i) % CACHES;
        if (req_vld[n*CACHES+c]) begin
          if (!found) begin
            found = 1;
            psrc[n] = c;
            pa[n] = req_addr[(n*CACHES+c)*ADDR_W +: ADDR_W];
          end else plose[n*CACHES+c] = 1'b1;
        end
      end
      pv[n] = found;
      if (found) lptr[n] = (psrc[n] + 1) % CACHES;
    end
  endtask

  initial begin
    int rp, dp;
    for (int n = 0; n < NODES; n++) begin lptr[n] = 0; pv[n] = 0; psrc[n] = 0; pa[n] = '0; end
    for (int k = 0; k < DEPTH; k++) begin tv[k] = 0; tl[k] = '0; end
    repeat (3) @(negedge clk);
    chk("R10 reset grant", 256'(grant), 256'(0));
    chk("R10 reset retry", 256'(retry), 256'(0));
    chk("R10 reset defer", 256'(defer), 256'(0));
    chk("R10 reset lanes", 256'(dlv_vld), 256'(0));
    rst_ni = 1'b1;
    for (int cyc = 0; cyc < 4000; cyc++) begin
      @(negedge clk);
      mon_step();
      rp = (cyc < 1500) ? 60 : (cyc < 3000) ? 20 : 90;
      dp = (cyc < 1500) ? 25 : (cyc < 3000) ? 70 : 10;
      if (cyc >= 3990) rp = 0;
      global_step(dp);
      local_step(rp);
    end
    repeat (2) begin
      @(negedge clk);
      mon_step();
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog R2 act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule